// File: doc/BRIEF.md
# Embedding Gather-Accumulate Engine

This block performs the sum-reduction step of a sparse embedding lookup. It accepts pages of embedding data in any arrival order and reduces them as they arrive. A request is set up first through a configuration port. The configuration gives the vector length, the number of result vectors, and a list of (input ID, result ID) pairs sorted by input ID. While the list loads, the engine groups the pairs by input ID. Each group records where its pairs start in the stored list and how many pairs it holds.

Each page holds exactly one embedding vector, and its page number equals the input ID of that vector. The page streams in one element per accepted beat and is held in a page buffer. The engine then looks up the group for that page number. For each pair in the group, it spends one cycle adding the whole page element-wise into the pair's result vector. Per-result counters compare the accumulated pairs against the number of pairs expected. A result becomes readable as final once its counter reaches that number, and a single done pulse marks the moment all results are final. The results are read out through a random-access read port.

Top module: `embedAccumEngine`

## Requirements
- R1: A cycle with `cfgStart` high begins a new request and zeroes every result element, every completion counter and both error flags. It latches `cfgVecCode` (0 gives 16 elements, 1 gives 32, 2 or 3 give 64), `cfgNumResults` and `cfgNumPairs`. Exactly `cfgNumPairs` pair beats with `cfgPairValid` high then follow. With zero pairs, the request is configured at once.
- R2: A pair whose input ID is lower than the input ID of the last kept pair is dropped, and `errUnsorted` is set. The flag stays set until the next `cfgStart`. Equal input IDs are allowed.
- R3: A sorted pair whose result ID is at least `cfgNumResults`, or at least the result capacity, is dropped, and `errRange` is set until the next `cfgStart`.
- R4: `pageReady` is high only while the engine is configured and waiting for page data. After reset, and until the pair list has fully loaded, `pageReady` stays low. A page consists of as many accepted beats as the vector length. `pageNum` is taken on the first beat, and element i arrives on beat i.
- R5: After page P is accepted, every kept pair with input ID P adds element i of the page into element i of its result. The addition is in 32-bit two's complement and wraps.
- R6: A page whose number matches no kept pair has no effect on results, done flags or error flags. A page that repeats one already reduced in the same request also has no effect.
- R7: `resDone[r]` is high once every kept pair mapped to result r has been accumulated. A result with no kept pairs is done as soon as configuration ends. Bits at or above `cfgNumResults` are low. A done bit stays high until the next `cfgStart`.
- R8: `allDone` is a one-cycle pulse, raised exactly once per request, on the cycle after every result first shows done. This includes a request that has nothing to accumulate.
- R9: `rdData` shows, without a clock delay, element `rdElem` of result `rdRes`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgStart | input | 1 | Begin a new request |
| cfgVecCode | input | 2 | Vector length code |
| cfgNumPairs | input | 7 | Number of pair beats that follow |
| cfgNumResults | input | 4 | Number of result vectors |
| cfgPairValid | input | 1 | Pair beat strobe |
| cfgInputId | input | 16 | Input ID of the pair |
| cfgResultId | input | 4 | Result ID of the pair |
| pageValid | input | 1 | Page data beat valid |
| pageReady | output | 1 | Engine accepts page data |
| pageNum | input | 16 | Page number, taken on the first beat |
| pageData | input | 32 | Page element |
| rdRes | input | 3 | Result index to read |
| rdElem | input | 6 | Element index to read |
| rdData | output | 32 | Selected result element |
| resDone | output | 8 | Per-result completion flags |
| allDone | output | 1 | One-cycle pulse when all results are final |
| errUnsorted | output | 1 | Sticky flag: an unsorted pair was dropped |
| errRange | output | 1 | Sticky flag: an out-of-range pair was dropped |

## Verification
The bench builds the engine with its default parameters: 32-bit elements, 16-bit page numbers, 64 pairs and 8 results. With these values, a request can fill the whole pair list and spread it over all eight results, and it can also use each of the three vector lengths. The page values are large odd multiples of the page and element indices, so every sum wraps. Expected sums and done flags are computed arithmetically from the pair list and the set of pages sent so far. They are compared against every element of every active result at intermediate points and at the end of each request. The request patterns cover duplicated input IDs, permuted page orders, stray and repeated pages, dropped pairs, results with no pairs, and an empty list.

// File: rtl/gaPkg.sv
package gaPkg;
  localparam int MIN_VLEN = 16;
  localparam int MAX_VLEN = 64;
  localparam int VIDX_W = $clog2(MAX_VLEN);
  localparam int VLEN_W = VIDX_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CAPTURE,
    ST_LOOKUP,
    ST_ACCUM
  } gaStateT;

  typedef struct packed {
    logic              clearAll;
    logic              capWrite;
    logic              accumEn;
    logic [VIDX_W-1:0] capIdx;
  } gaStrobeT;

  function automatic logic [VLEN_W-1:0] vecElemsOf(input logic [1:0] code);
    case (code)
      2'd0:    return VLEN_W'(MIN_VLEN);
      2'd1:    return VLEN_W'(2 * MIN_VLEN);
      default: return VLEN_W'(MAX_VLEN);
    endcase
  endfunction
endpackage

// File: rtl/gaDatapath.sv
module gaDatapath
  import gaPkg::*;
#(
  parameter int ELEM_W  = 32,
  parameter int MAX_RES = 8,
  parameter int RES_IW  = $clog2(MAX_RES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gaStrobeT          strb,
  input  logic [RES_IW-1:0] accumRes,
  input  logic [VLEN_W-1:0] vecElems,
  input  logic [ELEM_W-1:0] pageData,
  input  logic [RES_IW-1:0] rdRes,
  input  logic [VIDX_W-1:0] rdElem,
  output logic [ELEM_W-1:0] rdData
);
  logic [ELEM_W-1:0] pageBuf [MAX_VLEN];
  logic [ELEM_W-1:0] resMem  [MAX_RES][MAX_VLEN];

  always_ff @(posedge clk) begin
    if (strb.capWrite) pageBuf[strb.capIdx] <= pageData;
  end

  // one whole-vector add per accumulate strobe; lanes past the vector length hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < MAX_RES; r++)
        for (int e = 0; e < MAX_VLEN; e++) resMem[r][e] <= '0;
    end else if (strb.clearAll) begin
      for (int r = 0; r < MAX_RES; r++)
        for (int e = 0; e < MAX_VLEN; e++) resMem[r][e] <= '0;
    end else if (strb.accumEn) begin
      for (int e = 0; e < MAX_VLEN; e++)
        if (e < int'(vecElems))
          resMem[accumRes][e] <= resMem[accumRes][e] + pageBuf[e];
    end
  end

  assign rdData = resMem[rdRes][rdElem];

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearAll |=> (resMem[0][0] == '0 && resMem[MAX_RES-1][MAX_VLEN-1] == '0)) else $error("clear"); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.accumEn && strb.capWrite)) else $error("strobe overlap"); // R4
endmodule

// File: rtl/gaCtrl.sv
module gaCtrl
  import gaPkg::*;
#(
  parameter int PAGE_W    = 16,
  parameter int MAX_PAIRS = 64,
  parameter int MAX_RES   = 8,
  parameter int CNT_W     = $clog2(MAX_PAIRS + 1),
  parameter int PIDX_W    = $clog2(MAX_PAIRS),
  parameter int RES_IW    = $clog2(MAX_RES),
  parameter int RID_W     = RES_IW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgStart,
  input  logic [1:0]         cfgVecCode,
  input  logic [CNT_W-1:0]   cfgNumPairs,
  input  logic [RID_W-1:0]   cfgNumResults,
  input  logic               cfgPairValid,
  input  logic [PAGE_W-1:0]  cfgInputId,
  input  logic [RID_W-1:0]   cfgResultId,
  input  logic               pageValid,
  input  logic [PAGE_W-1:0]  pageNum,
  output logic               pageReady,
  output gaStrobeT           strb,
  output logic [RES_IW-1:0]  accumRes,
  output logic [VLEN_W-1:0]  vecElems,
  output logic [MAX_RES-1:0] resDone,
  output logic               allDone,
  output logic               errUnsorted,
  output logic               errRange
);
  gaStateT            state;
  logic [1:0]         vecCode;
  logic [RID_W-1:0]   numRes;
  logic [CNT_W-1:0]   pairLeft, storeIdx, grpCount;
  logic [PAGE_W-1:0]  lastId, curPage;
  logic               haveLast, doneSeen;
  logic [VIDX_W-1:0]  beatIdx;
  logic [PIDX_W-1:0]  accPtr;
  logic [CNT_W-1:0]   accLeft;

  logic [PAGE_W-1:0]  grpId    [MAX_PAIRS];
  logic [PIDX_W-1:0]  grpStart [MAX_PAIRS];
  logic [CNT_W-1:0]   grpLen   [MAX_PAIRS];
  logic [MAX_PAIRS-1:0] grpSeen;
  logic [RES_IW-1:0]  resList  [MAX_PAIRS];
  logic [CNT_W-1:0]   target   [MAX_RES];
  logic [CNT_W-1:0]   cnt      [MAX_RES];

  logic configured, pairUnsorted, pairInRange, pairKeep, pairNewGrp, pairBeat, pairWrite;
  logic beatFire, lastBeat, hit, allNow;
  logic [PIDX_W-1:0] hitIdx, grpTop;
  logic [MAX_RES-1:0] resMask;

  assign configured   = (state == ST_CAPTURE) || (state == ST_LOOKUP) || (state == ST_ACCUM);
  assign pageReady    = (state == ST_CAPTURE);
  assign vecElems     = vecElemsOf(vecCode);
  assign pairUnsorted = haveLast && (cfgInputId < lastId);
  assign pairInRange  = (cfgResultId < numRes) && (int'(cfgResultId) < MAX_RES);
  assign pairKeep     = !pairUnsorted && pairInRange && (storeIdx < CNT_W'(MAX_PAIRS));
  assign pairNewGrp   = !haveLast || (cfgInputId != lastId);
  assign pairBeat     = (state == ST_LOAD) && cfgPairValid && !cfgStart;
  assign pairWrite    = pairBeat && pairKeep;
  assign beatFire     = pageReady && pageValid && !cfgStart;
  assign lastBeat     = ({1'b0, beatIdx} == (vecElems - VLEN_W'(1)));
  assign grpTop       = grpCount[PIDX_W-1:0] - PIDX_W'(1);
  assign accumRes     = resList[accPtr];

  // group IDs rise strictly, so at most one entry matches the page
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int g = 0; g < MAX_PAIRS; g++) begin
      if (g < int'(grpCount) && grpId[g] == curPage) begin
        hit    = 1'b1;
        hitIdx = PIDX_W'(g);
      end
    end
  end

  always_comb begin
    strb.clearAll = cfgStart;
    strb.capWrite = beatFire;
    strb.capIdx   = beatIdx;
    strb.accumEn  = (state == ST_ACCUM) && !cfgStart;
  end

  for (genvar r = 0; r < MAX_RES; r++) begin : g_done
    assign resMask[r] = (RID_W'(r) < numRes);
    assign resDone[r] = configured && resMask[r] && (cnt[r] == target[r]);

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      configured |-> cnt[r] <= target[r]) else $error("counter overrun"); // R6
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (resDone[r] && !cfgStart) |=> resDone[r]) else $error("done dropped"); // R7
  end

  assign allNow = configured && ((resDone | ~resMask) == {MAX_RES{1'b1}});

  // pair list and page table storage
  always_ff @(posedge clk) begin
    if (pairWrite) begin
      resList[storeIdx[PIDX_W-1:0]] <= cfgResultId[RES_IW-1:0];
      if (pairNewGrp) begin
        grpId[grpCount[PIDX_W-1:0]]    <= cfgInputId;
        grpStart[grpCount[PIDX_W-1:0]] <= storeIdx[PIDX_W-1:0];
        grpLen[grpCount[PIDX_W-1:0]]   <= CNT_W'(1);
      end else begin
        grpLen[grpTop] <= grpLen[grpTop] + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      vecCode     <= '0;
      numRes      <= '0;
      pairLeft    <= '0;
      storeIdx    <= '0;
      grpCount    <= '0;
      lastId      <= '0;
      curPage     <= '0;
      haveLast    <= 1'b0;
      doneSeen    <= 1'b0;
      beatIdx     <= '0;
      accPtr      <= '0;
      accLeft     <= '0;
      grpSeen     <= '0;
      allDone     <= 1'b0;
      errUnsorted <= 1'b0;
      errRange    <= 1'b0;
      for (int r = 0; r < MAX_RES; r++) begin
        target[r] <= '0;
        cnt[r]    <= '0;
      end
    end else begin
      allDone <= 1'b0;
      if (cfgStart) begin
        vecCode     <= cfgVecCode;
        numRes      <= cfgNumResults;
        pairLeft    <= cfgNumPairs;
        storeIdx    <= '0;
        grpCount    <= '0;
        haveLast    <= 1'b0;
        doneSeen    <= 1'b0;
        beatIdx     <= '0;
        grpSeen     <= '0;
        errUnsorted <= 1'b0;
        errRange    <= 1'b0;
        for (int r = 0; r < MAX_RES; r++) begin
          target[r] <= '0;
          cnt[r]    <= '0;
        end
        state <= (cfgNumPairs == '0) ? ST_CAPTURE : ST_LOAD;
      end else begin
        if (allNow && !doneSeen) begin
          allDone  <= 1'b1;
          doneSeen <= 1'b1;
        end
        case (state)
          ST_LOAD: if (cfgPairValid) begin
            if (pairUnsorted) errUnsorted <= 1'b1;
            else if (!pairInRange) errRange <= 1'b1;
            if (pairKeep) begin
              target[cfgResultId[RES_IW-1:0]] <= target[cfgResultId[RES_IW-1:0]] + CNT_W'(1);
              storeIdx <= storeIdx + CNT_W'(1);
              lastId   <= cfgInputId;
              haveLast <= 1'b1;
              if (pairNewGrp) grpCount <= grpCount + CNT_W'(1);
            end
            pairLeft <= pairLeft - CNT_W'(1);
            if (pairLeft == CNT_W'(1)) state <= ST_CAPTURE;
          end
          ST_CAPTURE: if (pageValid) begin
            if (beatIdx == '0) curPage <= pageNum;
            if (lastBeat) begin
              beatIdx <= '0;
              state   <= ST_LOOKUP;
            end else begin
              beatIdx <= beatIdx + VIDX_W'(1);
            end
          end
          ST_LOOKUP: begin
            if (hit && !grpSeen[hitIdx]) begin
              grpSeen[hitIdx] <= 1'b1;
              accPtr          <= grpStart[hitIdx];
              accLeft         <= grpLen[hitIdx];
              state           <= ST_ACCUM;
            end else begin
              state <= ST_CAPTURE;
            end
          end
          ST_ACCUM: begin
            cnt[accumRes] <= cnt[accumRes] + CNT_W'(1);
            accPtr        <= accPtr + PIDX_W'(1);
            accLeft       <= accLeft - CNT_W'(1);
            if (accLeft == CNT_W'(1)) state <= ST_CAPTURE;
          end
          default: ;
        endcase
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    allDone |=> !allDone) else $error("done pulse too long"); // R8
  AST_UNSORTED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (errUnsorted && !cfgStart) |=> errUnsorted) else $error("flag lost"); // R2
  AST_RANGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (errRange && !cfgStart) |=> errRange) else $error("flag lost"); // R3
endmodule

// File: rtl/embedAccumEngine.sv
module embedAccumEngine
  import gaPkg::*;
#(
  parameter int ELEM_W    = 32,
  parameter int PAGE_W    = 16,
  parameter int MAX_PAIRS = 64,
  parameter int MAX_RES   = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfgStart,
  input  logic [1:0]                         cfgVecCode,
  input  logic [$clog2(MAX_PAIRS+1)-1:0]     cfgNumPairs,
  input  logic [$clog2(MAX_RES):0]           cfgNumResults,
  input  logic                               cfgPairValid,
  input  logic [PAGE_W-1:0]                  cfgInputId,
  input  logic [$clog2(MAX_RES):0]           cfgResultId,
  input  logic                               pageValid,
  output logic                               pageReady,
  input  logic [PAGE_W-1:0]                  pageNum,
  input  logic [ELEM_W-1:0]                  pageData,
  input  logic [$clog2(MAX_RES)-1:0]         rdRes,
  input  logic [gaPkg::VIDX_W-1:0]           rdElem,
  output logic [ELEM_W-1:0]                  rdData,
  output logic [MAX_RES-1:0]                 resDone,
  output logic                               allDone,
  output logic                               errUnsorted,
  output logic                               errRange
);
  localparam int RES_IW = $clog2(MAX_RES);

  gaStrobeT          strb;
  logic [RES_IW-1:0] accumRes;
  logic [VLEN_W-1:0] vecElems;

  gaCtrl #(
    .PAGE_W(PAGE_W), .MAX_PAIRS(MAX_PAIRS), .MAX_RES(MAX_RES)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n),
    .cfgStart(cfgStart), .cfgVecCode(cfgVecCode), .cfgNumPairs(cfgNumPairs),
    .cfgNumResults(cfgNumResults), .cfgPairValid(cfgPairValid),
    .cfgInputId(cfgInputId), .cfgResultId(cfgResultId),
    .pageValid(pageValid), .pageNum(pageNum), .pageReady(pageReady),
    .strb(strb), .accumRes(accumRes), .vecElems(vecElems),
    .resDone(resDone), .allDone(allDone),
    .errUnsorted(errUnsorted), .errRange(errRange)
  );

  gaDatapath #(
    .ELEM_W(ELEM_W), .MAX_RES(MAX_RES)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .accumRes(accumRes),
    .vecElems(vecElems), .pageData(pageData),
    .rdRes(rdRes), .rdElem(rdElem), .rdData(rdData)
  );
endmodule

// File: tb/tb_embedAccumEngine.sv
`timescale 1ns/1ps
module tb_embedAccumEngine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgStart = 1'b0;
  logic [1:0]  cfgVecCode = '0;
  logic [6:0]  cfgNumPairs = '0;
  logic [3:0]  cfgNumResults = '0;
  logic        cfgPairValid = 1'b0;
  logic [15:0] cfgInputId = '0;
  logic [3:0]  cfgResultId = '0;
  logic        pageValid = 1'b0;
  logic        pageReady;
  logic [15:0] pageNum = '0;
  logic [31:0] pageData = '0;
  logic [2:0]  rdRes = '0;
  logic [5:0]  rdElem = '0;
  logic [31:0] rdData;
  logic [7:0]  resDone;
  logic        allDone, errUnsorted, errRange;

  embedAccumEngine dut (
    .clk(clk), .rst_n(rst_n), .cfgStart(cfgStart), .cfgVecCode(cfgVecCode),
    .cfgNumPairs(cfgNumPairs), .cfgNumResults(cfgNumResults),
    .cfgPairValid(cfgPairValid), .cfgInputId(cfgInputId), .cfgResultId(cfgResultId),
    .pageValid(pageValid), .pageReady(pageReady), .pageNum(pageNum), .pageData(pageData),
    .rdRes(rdRes), .rdElem(rdElem), .rdData(rdData), .resDone(resDone),
    .allDone(allDone), .errUnsorted(errUnsorted), .errRange(errRange)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  int doneCount = 0;

  int cIn [64];
  int cRes [64];
  bit keep [64];
  int cNum, cNumRes, cCode;
  bit expErrU, expErrR;
  bit sent [1024];

  always @(posedge clk) begin
    #1;
    if (allDone) doneCount++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic int vecN(input int code);
    return (code == 0) ? 16 : (code == 1) ? 32 : 64;
  endfunction

  function automatic logic [31:0] pageVal(input int p, input int e);
    return 32'(p) * 32'h0100_0193 + 32'(e) * 32'h9E37_79B9;
  endfunction

  function automatic logic [31:0] expRes(input int r, input int e);
    logic [31:0] s = '0;
    for (int i = 0; i < cNum; i++)
      if (keep[i] && cRes[i] == r && sent[cIn[i]]) s = s + pageVal(cIn[i], e);
    return s;
  endfunction

  function automatic logic [7:0] expDone();
    logic [7:0] d = '0;
    for (int r = 0; r < 8; r++) begin
      if (r < cNumRes) begin
        d[r] = 1'b1;
        for (int i = 0; i < cNum; i++)
          if (keep[i] && cRes[i] == r && !sent[cIn[i]]) d[r] = 1'b0;
      end
    end
    return d;
  endfunction

  task automatic configure(input int code, input int numRes, input int num);
    int lastKept = -1;
    int kc = 0;
    cCode = code; cNumRes = numRes; cNum = num;
    expErrU = 0; expErrR = 0;
    for (int p = 0; p < 1024; p++) sent[p] = 0;
    for (int i = 0; i < num; i++) begin
      bit uns, rng;
      uns = (lastKept >= 0) && (cIn[i] < lastKept);
      rng = !uns && (cRes[i] >= numRes || cRes[i] >= 8);
      keep[i] = !uns && !rng && kc < 64;
      if (uns) expErrU = 1;
      if (rng) expErrR = 1;
      if (keep[i]) begin lastKept = cIn[i]; kc++; end
    end
    @(negedge clk);
    doneCount = 0;
    cfgStart = 1; cfgVecCode = 2'(code); cfgNumResults = 4'(numRes); cfgNumPairs = 7'(num);
    @(negedge clk);
    cfgStart = 0;
    for (int i = 0; i < num; i++) begin
      cfgPairValid = 1; cfgInputId = 16'(cIn[i]); cfgResultId = 4'(cRes[i]);
      @(negedge clk);
    end
    cfgPairValid = 0;
  endtask

  task automatic waitReady();
    int t = 0;
    while (!pageReady && t < 300) begin @(negedge clk); t++; end
    chk("R4", "ready returns", {31'b0, pageReady}, 32'd1);
  endtask

  task automatic sendPage(input int p);
    int n = vecN(cCode);
    for (int e = 0; e < n; e++) begin
      bit rdy;
      pageValid = 1; pageNum = 16'(p); pageData = pageVal(p, e);
      do begin
        rdy = pageReady;
        @(negedge clk);
      end while (!rdy);
    end
    pageValid = 0;
    sent[p] = 1;
    waitReady();
  endtask

  task automatic checkAll(input string tag);
    chk("R7", {tag, " resDone"}, {24'b0, resDone}, {24'b0, expDone()});
    chk("R2", {tag, " errUnsorted"}, {31'b0, errUnsorted}, {31'b0, expErrU});
    chk("R3", {tag, " errRange"}, {31'b0, errRange}, {31'b0, expErrR});
    for (int r = 0; r < cNumRes; r++)
      for (int e = 0; e < vecN(cCode); e++) begin
        rdRes = 3'(r); rdElem = 6'(e);
        #1;
        chk("R5 R9", $sformatf("%s res%0d el%0d", tag, r, e), rdData, expRes(r, e));
      end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R4 R7 R8: reset state, page data offered before any configuration
    chk("R4", "reset ready", {31'b0, pageReady}, 32'd0);
    chk("R7", "reset done", {24'b0, resDone}, 32'd0);
    chk("R8", "reset pulse", {31'b0, allDone}, 32'd0);
    chk("R2", "reset err", {30'b0, errUnsorted, errRange}, 32'd0);
    pageValid = 1;
    repeat (5) @(negedge clk);
    chk("R4", "ready unconfigured", {31'b0, pageReady}, 32'd0);
    pageValid = 0;

    // Request A: 16 elements, duplicated input IDs
    cIn[0]=3; cRes[0]=0; cIn[1]=3; cRes[1]=2; cIn[2]=5; cRes[2]=1; cIn[3]=9; cRes[3]=0;
    cIn[4]=9; cRes[4]=1; cIn[5]=9; cRes[5]=3; cIn[6]=12; cRes[6]=2;
    configure(0, 4, 7);
    checkAll("R1 A zeroed");
    sendPage(12); checkAll("A p12");
    sendPage(3);  checkAll("A p3");
    sendPage(99); checkAll("R6 A stray");
    sendPage(9);  checkAll("A p9");
    chk("R8", "A no early pulse", doneCount, 0);
    sendPage(5);
    repeat (3) @(negedge clk);
    checkAll("A final");
    chk("R8", "A pulse count", doneCount, 1);
    sendPage(3);
    repeat (3) @(negedge clk);
    checkAll("R6 A repeat");
    chk("R8", "A no second pulse", doneCount, 1);

    // Request B: 64 elements, full list, all results, permuted page order
    for (int i = 0; i < 64; i++) begin cIn[i] = 100 + i / 3; cRes[i] = (i * 5) % 8; end
    configure(2, 8, 64);
    for (int g = 0; g < 22; g++) begin
      sendPage(100 + (g * 7) % 22);
      if (g == 10) checkAll("B half");
    end
    repeat (3) @(negedge clk);
    checkAll("B final");
    chk("R8", "B pulse count", doneCount, 1);

    // Request C: 32 elements, dropped pairs, a result with no pairs
    cIn[0]=2; cRes[0]=0; cIn[1]=4; cRes[1]=1; cIn[2]=1; cRes[2]=0; cIn[3]=4; cRes[3]=5;
    cIn[4]=6; cRes[4]=0; cIn[5]=6; cRes[5]=7;
    configure(1, 3, 6);
    checkAll("R2 R3 C loaded");
    sendPage(1); checkAll("R6 C dropped page");
    sendPage(6); sendPage(2); sendPage(4);
    repeat (3) @(negedge clk);
    checkAll("C final");
    chk("R8", "C pulse count", doneCount, 1);

    // Request D: empty list, errors cleared by the new start
    configure(3, 2, 0);
    repeat (3) @(negedge clk);
    checkAll("R1 D empty");
    chk("R8", "D pulse count", doneCount, 1);
    chk("R4", "D ready", {31'b0, pageReady}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule